// File: doc/BRIEF.md
# Bit-Manipulation Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a small programmable engine. A 6-bit operation code selects one function of two operands: A, taken from the second register field, and B, the third operand. The block returns a full-width result. It also returns a pair of compare flags that report whether A and B are equal.

Besides the common add, subtract and bitwise functions, the unit has several less usual operations. Shifts come in both operand orders, and subtraction comes in normal, reversed and minus-one forms. There is a highest-set-bit index, and an XOR whose result is clipped to the span of B's top set bit. A sign extension takes its width from B. Two narrow multiplies keep a 24-bit product and widen it either signed or unsigned. The block has no clock and no state: the result follows the inputs within the same cycle, and the surrounding pipeline registers it.

Top module: `bmalu_core`

## Requirements
- R1: Shift amounts use the low 5 bits of the count operand. Opcode 100000 gives A shifted left by B, and 100001 gives B shifted left by A. Opcodes 100010 and 100100 both give A shifted right logically by B.
- R2: Opcode 100110 rotates A right by the low 5 bits of B.
- R3: Opcode 101100 gives A+B and opcode 101101 gives A-B, both modulo 2^32.
- R4: Opcode 101111 gives B-A and opcode 110000 gives A-1-B, both modulo 2^32.
- R5: Opcode 110001 gives A AND B and 110100 gives A OR B. Opcodes 110101 and 000001 both give A XOR B. Opcode 110010 gives A AND NOT B.
- R6: Opcode 111011 gives the bit index (0..31) of the most significant set bit of A. An all-ones A gives 31, 0x7FFFFFFF gives 30, and zero gives 0.
- R7: Opcode 110011 gives (A XOR B) AND mask(h), where h is the highest-set-bit index of B as in R6 and mask(n) has bits n down to 0 set.
- R8: Opcode 111000 takes n = B[4:0], keeps bits n..0 of A, and fills every higher bit with A[n].
- R9: Opcode 101000 gives the low 24 bits of A*B, zero-extended to 32 bits.
- R10: Opcode 101010 gives the same low 24 bits of A*B, sign-extended from bit 23 to 32 bits.
- R11: On every opcode, eq_o is 1 exactly when A equals B, and ne_o is always the inverse of eq_o.
- R12: The compare opcode 111100 and every opcode not listed above give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Operation code |
| a_i | input | 32 | Operand A (second register) |
| b_i | input | 32 | Operand B (third operand) |
| res_o | output | 32 | Operation result |
| eq_o | output | 1 | A equals B |
| ne_o | output | 1 | A differs from B |

## Verification
The bench builds the block twice, both times at a 32-bit width and 24-bit product. Instance u0 uses the linear priority-scan highest-bit finder, and the second instance uses the logarithmic halving variant. The same expected stream is compared against both, so the two variants of the index logic must agree on the boundary operands: zero, a single low bit, 0x7FFFFFFF and all ones. Those operands feed the index operation, the clipped XOR and the sign extension alike. Shift and rotate counts of 0, 31, 32 and 33 confirm that only the low count bits matter. The 0x800000 multiply products separate the signed widening from the unsigned one.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;

   localparam int OPW = 6;

   localparam logic [OPW-1:0] OP_XOR_ALT = 6'b000001;
   localparam logic [OPW-1:0] OP_SHL     = 6'b100000;
   localparam logic [OPW-1:0] OP_SHL_REV = 6'b100001;
   localparam logic [OPW-1:0] OP_SHR_A   = 6'b100010;
   localparam logic [OPW-1:0] OP_SHR_B   = 6'b100100;
   localparam logic [OPW-1:0] OP_ROR     = 6'b100110;
   localparam logic [OPW-1:0] OP_MULU    = 6'b101000;
   localparam logic [OPW-1:0] OP_MULS    = 6'b101010;
   localparam logic [OPW-1:0] OP_ADD     = 6'b101100;
   localparam logic [OPW-1:0] OP_SUB     = 6'b101101;
   localparam logic [OPW-1:0] OP_SUB_REV = 6'b101111;
   localparam logic [OPW-1:0] OP_SUB_M1  = 6'b110000;
   localparam logic [OPW-1:0] OP_AND     = 6'b110001;
   localparam logic [OPW-1:0] OP_ANDN    = 6'b110010;
   localparam logic [OPW-1:0] OP_XCLIP   = 6'b110011;
   localparam logic [OPW-1:0] OP_OR      = 6'b110100;
   localparam logic [OPW-1:0] OP_XOR     = 6'b110101;
   localparam logic [OPW-1:0] OP_SEXT    = 6'b111000;
   localparam logic [OPW-1:0] OP_TOPBIT  = 6'b111011;
   localparam logic [OPW-1:0] OP_CMP     = 6'b111100;

   // highest-set-bit finder implementation
   typedef enum logic {
      TOPBIT_SCAN  = 1'b0,
      TOPBIT_HALVE = 1'b1
   } topbit_impl_e;

endpackage

// File: rtl/bmalu_topbit.sv
module bmalu_topbit
   import bmalu_pkg::*;
#(
   parameter int           WIDTH = 32,
   parameter topbit_impl_e IMPL  = TOPBIT_SCAN,
   localparam int          SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val_i,
   output logic [SHW-1:0]   idx_o
);

   generate
      if (IMPL == TOPBIT_SCAN) begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < WIDTH; i++) begin
               if (val_i[i]) idx_o = SHW'(i);
            end
         end
      end else begin : g_halve
         always_comb begin
            logic [WIDTH-1:0] v;
            v     = val_i;
            idx_o = '0;
            for (int k = SHW - 1; k >= 0; k--) begin
               if (|(v >> (1 << k))) begin
                  idx_o[k] = 1'b1;
                  v        = v >> (1 << k);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bmalu_shift.sv
module bmalu_shift #(
   parameter int  WIDTH = 32,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] shl_o,
   output logic [WIDTH-1:0] shl_rev_o,
   output logic [WIDTH-1:0] shr_o,
   output logic [WIDTH-1:0] ror_o
);

   logic [SHW-1:0]     cnt_b;
   logic [SHW-1:0]     cnt_a;
   logic [2*WIDTH-1:0] dbl;

   assign cnt_b = b_i[SHW-1:0];
   assign cnt_a = a_i[SHW-1:0];

   always_comb begin
      shl_o     = a_i << cnt_b;
      shl_rev_o = b_i << cnt_a;
      shr_o     = a_i >> cnt_b;
      dbl       = {a_i, a_i} >> cnt_b;
      ror_o     = dbl[WIDTH-1:0];
   end

endmodule

// File: rtl/bmalu_arith.sv
module bmalu_arith #(
   parameter int WIDTH = 32,
   parameter int MULW  = 24
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] add_o,
   output logic [WIDTH-1:0] sub_o,
   output logic [WIDTH-1:0] sub_rev_o,
   output logic [WIDTH-1:0] sub_m1_o,
   output logic [WIDTH-1:0] mulu_o,
   output logic [WIDTH-1:0] muls_o
);

   logic [MULW-1:0] prod;

   always_comb begin
      add_o     = a_i + b_i;
      sub_o     = a_i - b_i;
      sub_rev_o = b_i - a_i;
      sub_m1_o  = a_i + ~b_i;
      prod      = a_i[MULW-1:0] * b_i[MULW-1:0];
   end

   generate
      if (MULW == WIDTH) begin : g_full
         assign mulu_o = prod;
         assign muls_o = prod;
      end else begin : g_narrow
         assign mulu_o = {{(WIDTH-MULW){1'b0}}, prod};
         assign muls_o = {{(WIDTH-MULW){prod[MULW-1]}}, prod};
      end
   endgenerate

endmodule

// File: rtl/bmalu_bits.sv
module bmalu_bits #(
   parameter int  WIDTH = 32,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [SHW-1:0]   top_b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] xor_o,
   output logic [WIDTH-1:0] andn_o,
   output logic [WIDTH-1:0] xclip_o,
   output logic [WIDTH-1:0] sext_o
);

   localparam logic [SHW-1:0] TOP = SHW'(WIDTH - 1);

   logic [WIDTH-1:0] clip_mask;
   logic [WIDTH-1:0] ext_mask;
   logic [SHW-1:0]   ext_pos;
   logic             ext_sign;

   always_comb begin
      and_o     = a_i & b_i;
      or_o      = a_i | b_i;
      xor_o     = a_i ^ b_i;
      andn_o    = a_i & ~b_i;
      clip_mask = {WIDTH{1'b1}} >> (TOP - top_b_i);
      xclip_o   = xor_o & clip_mask;
      ext_pos   = b_i[SHW-1:0];
      ext_mask  = {WIDTH{1'b1}} >> (TOP - ext_pos);
      ext_sign  = a_i[ext_pos];
      sext_o    = (a_i & ext_mask) | (ext_sign ? ~ext_mask : '0);
   end

endmodule

// File: rtl/bmalu_core.sv
module bmalu_core
   import bmalu_pkg::*;
#(
   parameter int           WIDTH       = 32,
   parameter int           MULW        = 24,
   parameter topbit_impl_e TOPBIT_IMPL = TOPBIT_SCAN,
   localparam int          SHW         = $clog2(WIDTH)
) (
   input  logic [OPW-1:0]   op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             eq_o,
   output logic             ne_o
);

   generate
      if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("bmalu_core: WIDTH must be a power of two, at least 8");
      end
      if (MULW < 2 || MULW > WIDTH) begin : g_bad_mulw
         $error("bmalu_core: MULW must lie in 2..WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] shl, shl_rev, shr, ror;
   logic [WIDTH-1:0] add, sub, sub_rev, sub_m1, mulu, muls;
   logic [WIDTH-1:0] land, lor, lxor, landn, xclip, sext;
   logic [SHW-1:0]   top_a, top_b;

   bmalu_shift #(.WIDTH(WIDTH)) u_shift (
      .a_i(a_i), .b_i(b_i),
      .shl_o(shl), .shl_rev_o(shl_rev), .shr_o(shr), .ror_o(ror)
   );

   bmalu_arith #(.WIDTH(WIDTH), .MULW(MULW)) u_arith (
      .a_i(a_i), .b_i(b_i),
      .add_o(add), .sub_o(sub), .sub_rev_o(sub_rev), .sub_m1_o(sub_m1),
      .mulu_o(mulu), .muls_o(muls)
   );

   bmalu_topbit #(.WIDTH(WIDTH), .IMPL(TOPBIT_IMPL)) u_top_a (
      .val_i(a_i), .idx_o(top_a)
   );

   bmalu_topbit #(.WIDTH(WIDTH), .IMPL(TOPBIT_IMPL)) u_top_b (
      .val_i(b_i), .idx_o(top_b)
   );

   bmalu_bits #(.WIDTH(WIDTH)) u_bits (
      .a_i(a_i), .b_i(b_i), .top_b_i(top_b),
      .and_o(land), .or_o(lor), .xor_o(lxor), .andn_o(landn),
      .xclip_o(xclip), .sext_o(sext)
   );

   always_comb begin
      unique case (op_i)
         OP_SHL:              res_o = shl;
         OP_SHL_REV:          res_o = shl_rev;
         OP_SHR_A, OP_SHR_B:  res_o = shr;
         OP_ROR:              res_o = ror;
         OP_ADD:              res_o = add;
         OP_SUB:              res_o = sub;
         OP_SUB_REV:          res_o = sub_rev;
         OP_SUB_M1:           res_o = sub_m1;
         OP_MULU:             res_o = mulu;
         OP_MULS:             res_o = muls;
         OP_AND:              res_o = land;
         OP_OR:               res_o = lor;
         OP_XOR, OP_XOR_ALT:  res_o = lxor;
         OP_ANDN:             res_o = landn;
         OP_XCLIP:            res_o = xclip;
         OP_SEXT:             res_o = sext;
         OP_TOPBIT:           res_o = WIDTH'(top_a);
         default:             res_o = '0;
      endcase
   end

   assign eq_o = (a_i == b_i);
   assign ne_o = ~eq_o;

endmodule

// File: rtl/bmalu_chk.sv
module bmalu_chk
   import bmalu_pkg::*;
#(
   parameter int  WIDTH = 32,
   parameter int  MULW  = 24,
   localparam int SHW   = $clog2(WIDTH)
) (
   input logic [OPW-1:0]   op_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [WIDTH-1:0] res_o,
   input logic             eq_o,
   input logic             ne_o
);

   logic [WIDTH-1:0] low_fill;

   always_comb begin
      low_fill = (WIDTH'(1) << b_i[SHW-1:0]) - WIDTH'(1);

      AST_FLAGS_EXCLUSIVE: assert ((eq_o ^ ne_o) == 1'b1); // R11

      if (op_i == OP_SHL)
         AST_SHL_LOW_ZERO: assert ((res_o & low_fill) == '0); // R1

      if (op_i == OP_SUB)
         AST_SUB_INVERSE: assert (res_o + b_i == a_i); // R3

      if (op_i == OP_SUB_REV)
         AST_RSUB_INVERSE: assert (res_o + a_i == b_i); // R4

      if (op_i == OP_SUB_M1)
         AST_SUBM1_INVERSE: assert (res_o + b_i + WIDTH'(1) == a_i); // R4

      if (op_i == OP_ANDN)
         AST_ANDN_DISJOINT: assert ((res_o & b_i) == '0); // R5

      if (op_i == OP_TOPBIT && a_i != '0)
         AST_TOPBIT_LEADS: assert ((a_i >> res_o[SHW-1:0]) == WIDTH'(1) && res_o < WIDTH'(WIDTH)); // R6

      if (op_i == OP_XCLIP && b_i != '0)
         AST_XCLIP_BOUNDED: assert ({1'b0, res_o} < {b_i, 1'b0}); // R7
   end

   generate
      if (MULW < WIDTH) begin : g_mul_chk
         always_comb begin
            if (op_i == OP_MULU)
               AST_MULU_UPPER_ZERO: assert (res_o[WIDTH-1:MULW] == '0); // R9
            if (op_i == OP_MULS)
               AST_MULS_UPPER_SIGN: assert ((&res_o[WIDTH-1:MULW-1]) || !(|res_o[WIDTH-1:MULW-1])); // R10
         end
      end
   endgenerate

endmodule

bind bmalu_core bmalu_chk #(.WIDTH(WIDTH), .MULW(MULW)) u_chk (
   .op_i(op_i), .a_i(a_i), .b_i(b_i),
   .res_o(res_o), .eq_o(eq_o), .ne_o(ne_o)
);

// File: tb/sim_bmalu_core.sv
`timescale 1ns/1ps
module sim_bmalu_core;
   import bmalu_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  op  = '0;
   logic [31:0] a   = '0;
   logic [31:0] b   = '0;
   logic [31:0] res0, res1;
   logic        eq0, ne0, eq1, ne1;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [31:0] q_res[$];
   bit          q_eq[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   bmalu_core #(.WIDTH(32), .MULW(24), .TOPBIT_IMPL(TOPBIT_SCAN)) u0 (
      .op_i(op), .a_i(a), .b_i(b), .res_o(res0), .eq_o(eq0), .ne_o(ne0)
   );

   bmalu_core #(.WIDTH(32), .MULW(24), .TOPBIT_IMPL(TOPBIT_HALVE)) u1 (
      .op_i(op), .a_i(a), .b_i(b), .res_o(res1), .eq_o(eq1), .ne_o(ne1)
   );

   function automatic int top_ref(input logic [31:0] x);
      int r = 0;
      for (int i = 31; i >= 0; i--) begin
         if (x[i]) begin r = i; break; end
      end
      return r;
   endfunction

   function automatic logic [31:0] span(input int n);
      logic [31:0] m = '0;
      for (int i = 0; i <= n; i++) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] model(input logic [5:0] o, input logic [31:0] x, input logic [31:0] y);
      int          sy = int'(y[4:0]);
      int          sx = int'(x[4:0]);
      logic [63:0] p;
      logic [31:0] m;
      case (o)
         6'b100000: return x << sy;
         6'b100001: return y << sx;
         6'b100010, 6'b100100: return x >> sy;
         6'b100110: return (sy == 0) ? x : ((x >> sy) | (x << (32 - sy)));
         6'b101100: return x + y;
         6'b101101: return x - y;
         6'b101111: return y - x;
         6'b110000: return x - 32'd1 - y;
         6'b110001: return x & y;
         6'b110100: return x | y;
         6'b110101, 6'b000001: return x ^ y;
         6'b110010: return x & ~y;
         6'b111011: return 32'(top_ref(x));
         6'b110011: return (x ^ y) & span(top_ref(y));
         6'b111000: begin
            m = span(sy);
            return x[sy] ? ((x & m) | ~m) : (x & m);
         end
         6'b101000: begin
            p = {32'd0, x} * {32'd0, y};
            return {8'h00, p[23:0]};
         end
         6'b101010: begin
            p = {32'd0, x} * {32'd0, y};
            return {{8{p[23]}}, p[23:0]};
         end
         default: return 32'd0;
      endcase
   endfunction

   task automatic apply(input logic [5:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
      @(posedge clk);
      #1;
      op = o; a = x; b = y;
      q_res.push_back(model(o, x, y));
      q_eq.push_back(x == y);
      q_tag.push_back(tag);
   endtask

   // monitor: compare at the falling edge after each drive
   always @(negedge clk) begin
      if (q_res.size() > 0) begin
         logic [31:0] er;
         bit          ee;
         string       t;
         er = q_res.pop_front();
         ee = q_eq.pop_front();
         t  = q_tag.pop_front();
         vectors++;
         if (res0 !== er || res1 !== er) begin
            fails++;
            $display("FAIL %s result op=%b a=%h b=%h u0=%h u1=%h expected=%h", t, op, a, b, res0, res1, er);
         end
         if (eq0 !== ee || eq1 !== ee || ne0 !== !ee || ne1 !== !ee) begin
            fails++;
            $display("FAIL R11 flags op=%b a=%h b=%h eq=%b/%b ne=%b/%b expected eq=%b", op, a, b, eq0, eq1, ne0, ne1, ee);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      logic [5:0]  ops [20];
      ops = '{6'b100000, 6'b100001, 6'b100010, 6'b100100, 6'b100110, 6'b101100, 6'b101101,
              6'b101111, 6'b110000, 6'b110001, 6'b110100, 6'b110101, 6'b000001, 6'b110010,
              6'b111011, 6'b110011, 6'b111000, 6'b101000, 6'b101010, 6'b111100};
      repeat (4) @(posedge clk);
      rst = 1'b0;

      // idle state: all-zero inputs, unmapped opcode
      apply(6'b000000, 32'h0, 32'h0, "R12 zero-input");
      // R1 shifts
      apply(6'b100000, 32'h0000_00F1, 32'd4, "R1 shl");
      apply(6'b100000, 32'h0000_00F1, 32'd36, "R1 shl count low bits");
      apply(6'b100001, 32'd3, 32'h0000_0101, "R1 reversed shl");
      apply(6'b100010, 32'h8000_0000, 32'd31, "R1 shr");
      apply(6'b100100, 32'hF000_0000, 32'd32, "R1 shr alt count 32");
      // R2 rotate
      apply(6'b100110, 32'h0000_0001, 32'd1, "R2 ror");
      apply(6'b100110, 32'h1234_5678, 32'd0, "R2 ror zero");
      apply(6'b100110, 32'h1234_5678, 32'd33, "R2 ror count 33");
      // R3 / R4 arithmetic
      apply(6'b101100, 32'hFFFF_FFFF, 32'd1, "R3 add wrap");
      apply(6'b101101, 32'd5, 32'd7, "R3 sub");
      apply(6'b101111, 32'd5, 32'd7, "R4 reversed sub");
      apply(6'b110000, 32'd10, 32'd3, "R4 sub minus one");
      apply(6'b110000, 32'd0, 32'd0, "R4 sub minus one zero");
      // R5 logic
      apply(6'b110001, 32'hF0F0_FF00, 32'hFF00_F0F0, "R5 and");
      apply(6'b110100, 32'hF0F0_0000, 32'h0000_0F0F, "R5 or");
      apply(6'b110101, 32'hAAAA_5555, 32'hFFFF_0000, "R5 xor");
      apply(6'b000001, 32'hAAAA_5555, 32'hFFFF_0000, "R5 xor alt");
      apply(6'b110010, 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R5 andn");
      // R6 highest set bit
      apply(6'b111011, 32'hFFFF_FFFF, 32'd0, "R6 all ones");
      apply(6'b111011, 32'h7FFF_FFFF, 32'd0, "R6 7fffffff");
      apply(6'b111011, 32'h0000_0000, 32'd0, "R6 zero");
      apply(6'b111011, 32'h0000_0001, 32'd0, "R6 one");
      apply(6'b111011, 32'h0001_0800, 32'd0, "R6 mid");
      // R7 clipped xor
      apply(6'b110011, 32'hFFFF_FFFF, 32'h0000_0010, "R7 xclip");
      apply(6'b110011, 32'hFFFF_FFFE, 32'h0000_0000, "R7 xclip b zero");
      apply(6'b110011, 32'h1234_5678, 32'h8000_0000, "R7 xclip full");
      // R8 sign extension
      apply(6'b111000, 32'h0000_0080, 32'd7, "R8 sext negative");
      apply(6'b111000, 32'h0000_0070, 32'd7, "R8 sext positive");
      apply(6'b111000, 32'h8765_4321, 32'd31, "R8 sext full");
      apply(6'b111000, 32'hFFFF_FFFE, 32'd0, "R8 sext width one");
      // R9 / R10 multiply
      apply(6'b101000, 32'h0080_0000, 32'd1, "R9 mulu bit23");
      apply(6'b101010, 32'h0080_0000, 32'd1, "R10 muls bit23");
      apply(6'b101000, 32'h0000_1234, 32'h0000_5678, "R9 mulu");
      apply(6'b101010, 32'hFFFF_FFFF, 32'd3, "R10 muls negative");
      // R11 flags, R12 compare/unmapped
      apply(6'b111100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R12 cmp equal");
      apply(6'b111100, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R12 cmp differ");
      apply(6'b011000, 32'h1111_1111, 32'h2222_2222, "R12 unmapped");
      apply(6'b111111, 32'h1111_1111, 32'h1111_1111, "R12 unmapped equal");

      // pseudo-random sweep over every listed opcode
      lf = 32'hACE1_2468;
      for (int i = 0; i < 600; i++) begin
         logic [31:0] x, y;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         x  = lf;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         y  = (i % 7 == 0) ? x : (i % 5 == 0 ? (lf >> (lf[4:0])) : lf);
         apply(ops[i % 20], x, y, "R1-R12 sweep");
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule